// File: doc/BRIEF.md
# Read Buffer Half-Crossing and Watermark Tracker

This block runs beside the read path of a serial flash emulator. It watches each byte address that the host reads from a two-half read buffer. The addresses only ever increase. The block tells the interrupt logic when reading has moved from one half into the other, so that firmware can refill the half that was just left. It also tells the interrupt logic when reading within the current half has reached a threshold set by software. Both indications are single-cycle pulses. An interrupt-state register outside the block latches them.

At the end of every read command the block records the address that follows the last byte read. Software can read that value to see how far the host has progressed. The buffer size and the threshold width are parameters. By default the buffer is 2048 bytes, so each half is 1024 bytes, and the threshold is 10 bits wide.

Top module: `rbt_tracker`

## Requirements
- R1: Address bit 10 (log2 of the buffer size minus one) selects the buffer half. When a strobed byte address has a half bit that differs from the tracked half, `flip_evt` is high for exactly the cycle after that strobe, and the tracked half takes the new value.
- R2: A command that reads a single byte is enough to cause a flip when that byte lies in the other half. This includes the last byte of a half read on its own.
- R3: While `rd_threshold` is zero, `wmark_evt` never fires.
- R4: Let T be a nonzero threshold. The offset of a byte within its half is address bits 9:0. Bytes at offsets 0 to T-2 raise no watermark. The byte at offset T-1 raises `wmark_evt` in the cycle after its strobe.
- R5: The watermark fires at most once per half. It is armed again only when the tracked half changes.
- R6: A flip and a watermark caused by the same strobe appear in the same cycle.
- R7: On the cycle after `cmd_end`, `last_addr` holds the address of the command's final byte plus one. In every other cycle `last_addr` keeps its value.
- R8: After reset the tracked half is 0, the watermark is armed, `last_addr` is zero and both event outputs are low.
- R9: A new threshold applies from the next strobe onward. Lowering it below an offset that has already been passed does not fire a watermark for the current half.
- R10: An event output is high only in the cycle right after a byte strobe, and never for two cycles in a row from a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_strobe | input | 1 | One byte is read this cycle |
| rd_addr | input | 32 | Address of the byte being read |
| cmd_end | input | 1 | The byte strobed this cycle is the last of its command (it may also arrive with no strobe) |
| rd_threshold | input | 10 | Watermark threshold; zero disables the watermark |
| flip_evt | output | 1 | One-cycle pulse: reading moved into the other half |
| wmark_evt | output | 1 | One-cycle pulse: offset T-1 reached in the current half |
| last_addr | output | 32 | Address that follows the final byte of the most recent command |

## Verification
The assertions check, on every cycle, the properties that can be seen from the ports alone. Events appear only after a strobe. A watermark appears only at offset T-1 with a nonzero threshold. `last_addr` changes only after `cmd_end`, and in that case it equals the final address plus one. Other behaviour depends on history that no single-cycle property can see: the watermark firing only once per half, re-arming after a half change, a lowered threshold not firing retroactively, and a jump of a whole buffer size causing no flip. Only the bench scenarios can show these, by counting the pulses over complete commands and comparing the counts with values worked out from the address sequence.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

    localparam int DEF_ADDR_W    = 32;
    localparam int DEF_BUF_BYTES = 2048;
    localparam int DEF_THR_W     = 10;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef struct packed {
        logic flip;
        logic wmark;
    } rbt_evt_t;

    function automatic half_e half_of(input logic sel_bit);
        return sel_bit ? HALF_HI : HALF_LO;
    endfunction

endpackage

// File: rtl/rbt_half_tracker.sv
module rbt_half_tracker
    import rbt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int HALF_BIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    output logic              half_chg,
    output logic              flip_q
);
    half_e cur_half;
    half_e new_half;

    always_comb begin
        new_half = half_of(addr[HALF_BIT]);
        half_chg = stb && (new_half != cur_half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_half <= HALF_LO;
            flip_q   <= 1'b0;
        end else begin
            flip_q <= half_chg;
            if (half_chg) begin
                cur_half <= new_half;
            end
        end
    end
endmodule

// File: rtl/rbt_watermark.sv
module rbt_watermark #(
    parameter int OFS_W = 10,
    parameter int THR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [OFS_W-1:0] ofs,
    input  logic [THR_W-1:0] thr,
    input  logic             half_chg,
    output logic             wm_q
);
    localparam int CMP_W = (OFS_W > THR_W ? OFS_W : THR_W) + 1;

    logic             armed;
    logic             armed_eff;
    logic             hit;
    logic [CMP_W-1:0] ofs_ext;
    logic [CMP_W-1:0] thr_m1;

    always_comb begin
        ofs_ext   = CMP_W'(ofs);
        thr_m1    = CMP_W'(thr) - CMP_W'(1);
        armed_eff = half_chg ? 1'b1 : armed;
        hit       = stb && (thr != '0) && armed_eff && (ofs_ext == thr_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
            wm_q  <= 1'b0;
        end else begin
            wm_q <= hit;
            if (stb) begin
                armed <= hit ? 1'b0 : armed_eff;
            end
        end
    end
endmodule

// File: rtl/rbt_last_addr.sv
module rbt_last_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cmd_end,
    output logic [ADDR_W-1:0] last_q
);
    logic [ADDR_W-1:0] pend_q;
    logic [ADDR_W-1:0] next_addr;

    always_comb begin
        next_addr = addr + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            last_q <= '0;
        end else begin
            if (stb) begin
                pend_q <= next_addr;
            end
            if (cmd_end) begin
                last_q <= stb ? next_addr : pend_q;
            end
        end
    end
endmodule

// File: rtl/rbt_tracker.sv
module rbt_tracker
    import rbt_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int BUF_BYTES = DEF_BUF_BYTES,
    parameter int THR_W     = DEF_THR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              cmd_end,
    input  logic [THR_W-1:0]  rd_threshold,
    output logic              flip_evt,
    output logic              wmark_evt,
    output logic [ADDR_W-1:0] last_addr
);
    localparam int HALF_BYTES = BUF_BYTES / 2;
    localparam int OFS_W      = $clog2(HALF_BYTES);
    localparam int HALF_BIT   = OFS_W;

    logic     half_chg;
    rbt_evt_t evt;

    rbt_half_tracker #(
        .ADDR_W  (ADDR_W),
        .HALF_BIT(HALF_BIT)
    ) u_half (
        .clk     (clk),
        .rst     (rst),
        .stb     (rd_strobe),
        .addr    (rd_addr),
        .half_chg(half_chg),
        .flip_q  (evt.flip)
    );

    rbt_watermark #(
        .OFS_W(OFS_W),
        .THR_W(THR_W)
    ) u_wm (
        .clk     (clk),
        .rst     (rst),
        .stb     (rd_strobe),
        .ofs     (rd_addr[OFS_W-1:0]),
        .thr     (rd_threshold),
        .half_chg(half_chg),
        .wm_q    (evt.wmark)
    );

    rbt_last_addr #(
        .ADDR_W(ADDR_W)
    ) u_last (
        .clk    (clk),
        .rst    (rst),
        .stb    (rd_strobe),
        .addr   (rd_addr),
        .cmd_end(cmd_end),
        .last_q (last_addr)
    );

    assign flip_evt  = evt.flip;
    assign wmark_evt = evt.wmark;
endmodule

// File: rtl/rbt_tracker_chk.sv
module rbt_tracker_chk #(
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 2048,
    parameter int THR_W     = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_strobe,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              cmd_end,
    input logic [THR_W-1:0]  rd_threshold,
    input logic              flip_evt,
    input logic              wmark_evt,
    input logic [ADDR_W-1:0] last_addr
);
    localparam int OFS_W = $clog2(BUF_BYTES / 2);
    localparam int CMP_W = (OFS_W > THR_W ? OFS_W : THR_W) + 1;

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R10
    flip_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        flip_evt |-> $past(rd_strobe));

    // R10
    wmark_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        wmark_evt |-> $past(rd_strobe));

    // R3
    wmark_zero_thr_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        wmark_evt |-> ($past(rd_threshold) != '0));

    // R4
    wmark_offset_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        wmark_evt |-> (CMP_W'($past(rd_addr[OFS_W-1:0])) == CMP_W'($past(rd_threshold)) - CMP_W'(1)));

    // R7
    last_hold_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        !$past(cmd_end) |-> $stable(last_addr));

    // R7
    last_value_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        ($past(cmd_end) && $past(rd_strobe)) |-> (last_addr == $past(rd_addr) + ADDR_W'(1)));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!flip_evt && !wmark_evt && last_addr == '0));
endmodule

bind rbt_tracker rbt_tracker_chk #(
    .ADDR_W   (ADDR_W),
    .BUF_BYTES(BUF_BYTES),
    .THR_W    (THR_W)
) u_rbt_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_strobe   (rd_strobe),
    .rd_addr     (rd_addr),
    .cmd_end     (cmd_end),
    .rd_threshold(rd_threshold),
    .flip_evt    (flip_evt),
    .wmark_evt   (wmark_evt),
    .last_addr   (last_addr)
);

// File: tb/test_rbt_tracker.sv
module test_rbt_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    // Each command: start address, byte count, threshold, expected flips, expected watermarks
    localparam logic [31:0] V_START [NV] = '{32'd0, 32'd1024, 32'd3071, 32'd4095, 32'd4096, 32'd4100,
        32'd4101, 32'd5124, 32'd6144, 32'd6145, 32'd6150, 32'd8199, 32'd9216};
    localparam int V_LEN [NV] = '{1024, 1024, 1, 1, 4, 1, 1023, 1, 1, 5, 1, 1, 1};
    localparam logic [9:0] V_THR [NV] = '{10'd0, 10'd0, 10'd0, 10'd0, 10'd5, 10'd5, 10'd5, 10'd5,
        10'd1, 10'd100, 10'd3, 10'd0, 10'd0};
    localparam int V_FLIP [NV] = '{0, 1, 1, 1, 1, 0, 1, 0, 1, 0, 0, 0, 1};
    localparam int V_WM   [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        cmd_end = 1'b0;
    logic [9:0]  rd_threshold = '0;
    logic        flip_evt;
    logic        wmark_evt;
    logic [31:0] last_addr;

    int n_chk = 0;
    int n_fail = 0;
    int flips, wms;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbt_tracker i_rbt_tracker (
        .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_addr(rd_addr), .cmd_end(cmd_end),
        .rd_threshold(rd_threshold), .flip_evt(flip_evt), .wmark_evt(wmark_evt), .last_addr(last_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic read_cmd(input logic [31:0] start, input int len);
        flips = 0;
        wms = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rd_strobe = 1'b1;
            rd_addr   = start + 32'(i);
            cmd_end   = (i == len - 1);
            @(posedge clk);
            #1;
            flips += int'(flip_evt);
            wms   += int'(wmark_evt);
        end
        @(negedge clk);
        rd_strobe = 1'b0;
        cmd_end   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs in reset
        check("R8 flip in reset", 32'(flip_evt), 0);
        check("R8 wmark in reset", 32'(wmark_evt), 0);
        check("R8 last_addr in reset", last_addr, 0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6 R7 R9 via the vector table
        for (int v = 0; v < NV; v++) begin
            rd_threshold = V_THR[v];
            read_cmd(V_START[v], V_LEN[v]);
            check($sformatf("R1/R2 flips vec %0d", v), 32'(flips), 32'(V_FLIP[v]));
            check($sformatf("R3/R4/R5/R6/R9 wmarks vec %0d", v), 32'(wms), 32'(V_WM[v]));
            check($sformatf("R7 last_addr vec %0d", v), last_addr, V_START[v] + 32'(V_LEN[v]));
        end

        // R10: idle cycle after a command carries no events
        @(posedge clk); #1;
        check("R10 idle flip", 32'(flip_evt), 0);
        check("R10 idle wmark", 32'(wmark_evt), 0);

        // R10: single strobe gives a one-cycle pulse
        rd_threshold = 10'd0;
        @(negedge clk); rd_strobe = 1'b1; rd_addr = 32'd10240; cmd_end = 1'b1;
        @(negedge clk); rd_strobe = 1'b0; cmd_end = 1'b0;
        check("R10 pulse present", 32'(flip_evt), 1);
        @(negedge clk);
        check("R10 pulse gone", 32'(flip_evt), 0);
        // R7: cmd_end with no strobe keeps the pending next address
        @(negedge clk); cmd_end = 1'b1;
        @(negedge clk); cmd_end = 1'b0;
        check("R7 end without strobe", last_addr, 32'd10241);

        // R8: reset mid-stream, half returns to 0 so a half-1 byte flips
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R8 last_addr after reset", last_addr, 0);
        rst = 1'b0;
        rd_threshold = 10'd1;
        read_cmd(32'd1024, 1);
        check("R8 flip after reset", 32'(flips), 1);
        check("R6 wmark same strobe", 32'(wms), 1);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule